// File: doc/BRIEF.md
# Display Controller Register Interface

This block is the register file that sits between a 32-bit register bus and the rest of a frame-based display controller. It holds six control words, two status words, two overlay control pairs, a cursor word, several small configuration words, one branch register per fetch channel and one frame-descriptor pointer per fetch channel. Each write is masked for its target register. Some writes also have side effects: they can set status bits on an edge of the enable bit, or clear status bits write-one-to-clear. Reads return the stored value and have no side effect.

The fetch engine reports back through two event ports. One is a bus-fault strobe that carries the channel number of the fault. The other is a set vector for status word 1. The block derives seven channel-active outputs from enable bits spread over several registers. It raises a level interrupt from status word 0 under a per-bit mask. Any access to an offset that is not mapped gives a one-cycle error pulse.

The bus uses a single-cycle handshake: one access per asserted strobe, with no wait states. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `dispctl_regs`

## Requirements
- R1: After synchronous active-low reset, every register, both status words, `rdata`, `err_o`, `irq_o` and all of `chan_active_o` read as zero.
- R2: Control words sit at offsets 0x000, 0x004, 0x008, 0x00C, 0x010 and 0x014 (words 0 to 5). Word 0 keeps bits 26..0, words 1 and 2 keep all bits, word 3 is masked with 0xEFFFFFFF, word 4 with 0x83FF81FF and word 5 with 0x3F3F3F3F.
- R3: Other stored words use these offsets and masks:
  - overlay-1 pair at 0x030 and 0x034, masked with 0x80FFFFFF and 0x000FFFFF;
  - overlay-2 pair at 0x038 and 0x03C, masked with 0x80FFFFFF and 0x007FFFFF;
  - cursor at 0x040, masked with 0x81FFFFE7;
  - command at 0x044, masked with 0xFF;
  - transparency colour at 0x048, masked with 0x00FFFFFF;
  - test at 0x04C, masked with 0x7FFF;
  - burst count at 0x050, masked with 0xF;
  - branch register of channel n at 0x060+4n, masked with 0xFFFFFFF3.
- R4: In control word 0, bit 0 is enable. A write to word 0 while the stored enable is 1 and the written bit 0 is 0 sets status word 0 bit 0 (disable done).
- R5: In control word 0, bit 2 selects the internal panel type. If control word 3 bits 11..8 are nonzero and a write to word 0 sets bit 0 with bit 2 clear, status word 0 bit 1 (abort) is set.
- R6: Status word 0 sits at 0x020. A write clears the set bits of written-data bits 11..0. If written-data bit 2 (bus fault) is 1, the channel field at bits 30..28 is also cleared. A fault event sets bit 2 and loads the field with the event's channel, and it wins over a clear in the same cycle.
- R7: Status word 1 sits at 0x024. A write clears the written-one bits under 0x003E3F3F. Event bits set it under the same mask, and a set wins over a clear in the same cycle.
- R8: Offsets 0x200..0x1000 form the descriptor region, with channel = (offset-0x200)>>4. Only subregister 0 of channels 0..6 is mapped. It stores the data with bits 3..0 forced to zero. Any other subregister or channel is unmapped.
- R9: The channel-active outputs follow these sources:
  - bit 0 follows control word 0 bit 0;
  - bit 1 is overlay-1 word bit 31 OR control word 0 bit 1 (dual scan);
  - bits 2, 3 and 4 follow overlay-2 word bit 31;
  - bit 5 follows cursor bit 31;
  - bit 6 stays 0.
  Each output changes on the cycle after the write.
- R10: Offset 0x054 is reserved. A write there changes nothing and raises no error, and a read there returns 0.
- R11: A read or write to an unmapped offset pulses `err_o` for exactly one cycle, the cycle after the access. The access changes no state, and a read of such an offset returns 0.
- R12: `irq_o` is high whenever a bit of status word 0 bits 11..0 is set and the matching bit of control word 0 bits 23..12 (1 = masked) is clear. It follows status with no added delay.
- R13: A read returns the stored value on `rdata` the cycle after the strobe, holds it until the next read, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 32 | Byte offset of the access |
| wdata | input | 32 | Write data |
| fault_vld | input | 1 | Bus-fault event from the fetch engine |
| fault_ch | input | 3 | Channel of the bus fault |
| stat1_evt | input | 32 | Set vector for status word 1 |
| rdata | output | 32 | Read data, registered |
| err_o | output | 1 | One-cycle pulse for an unmapped access |
| irq_o | output | 1 | Status-derived interrupt level |
| chan_active_o | output | 7 | Fetch-channel run requests |

## Verification
The hardest case to reach is the bus-fault channel field. Only the fault event port fills it, and only a status-0 clear with bit 2 set empties it. Clears of other bits must leave it alone, and a fault in the same cycle as a clear must win. The stimulus first raises a fault, then clears unrelated bits and reads back, then clears bit 2. Finally it fires a fault and a clear in the same cycle. The abort condition needs control word 3 loaded with a nonzero panel field before the enable write. It is tried both with and without the panel-type bit. A long random phase then mixes all offsets, including unmapped and reserved ones, with events, and compares against the bench's model on every clock.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_CTRL = 6;

    // fixed offsets
    localparam logic [31:0] OFS_CTRL0 = 32'h000;
    localparam logic [31:0] OFS_CTRL1 = 32'h004;
    localparam logic [31:0] OFS_CTRL2 = 32'h008;
    localparam logic [31:0] OFS_CTRL3 = 32'h00C;
    localparam logic [31:0] OFS_CTRL4 = 32'h010;
    localparam logic [31:0] OFS_CTRL5 = 32'h014;
    localparam logic [31:0] OFS_STAT0 = 32'h020;
    localparam logic [31:0] OFS_STAT1 = 32'h024;
    localparam logic [31:0] OFS_OV1A  = 32'h030;
    localparam logic [31:0] OFS_OV1B  = 32'h034;
    localparam logic [31:0] OFS_OV2A  = 32'h038;
    localparam logic [31:0] OFS_OV2B  = 32'h03C;
    localparam logic [31:0] OFS_CURS  = 32'h040;
    localparam logic [31:0] OFS_CMD   = 32'h044;
    localparam logic [31:0] OFS_TCOL  = 32'h048;
    localparam logic [31:0] OFS_TEST  = 32'h04C;
    localparam logic [31:0] OFS_BURST = 32'h050;
    localparam logic [31:0] OFS_RSVD  = 32'h054;
    localparam logic [31:0] OFS_BR    = 32'h060;
    localparam logic [31:0] OFS_DMA   = 32'h200;
    localparam logic [31:0] OFS_DMA_Z = 32'h1000;
    localparam logic [3:0]  DESC_SUB  = 4'h0;

    // write masks
    localparam logic [31:0] MSK_CTRL0 = 32'h07FF_FFFF;
    localparam logic [31:0] MSK_CTRL3 = 32'hEFFF_FFFF;
    localparam logic [31:0] MSK_CTRL4 = 32'h83FF_81FF;
    localparam logic [31:0] MSK_CTRL5 = 32'h3F3F_3F3F;
    localparam logic [31:0] MSK_OVA   = 32'h80FF_FFFF;
    localparam logic [31:0] MSK_OV1B  = 32'h000F_FFFF;
    localparam logic [31:0] MSK_OV2B  = 32'h007F_FFFF;
    localparam logic [31:0] MSK_CURS  = 32'h81FF_FFE7;
    localparam logic [31:0] MSK_CMD   = 32'h0000_00FF;
    localparam logic [31:0] MSK_TCOL  = 32'h00FF_FFFF;
    localparam logic [31:0] MSK_TEST  = 32'h0000_7FFF;
    localparam logic [31:0] MSK_BURST = 32'h0000_000F;
    localparam logic [31:0] MSK_BR    = 32'hFFFF_FFF3;
    localparam logic [31:0] MSK_DESC  = 32'hFFFF_FFF0;
    localparam logic [31:0] MSK_STAT1 = 32'h003E_3F3F;

    // bit positions
    localparam int unsigned B_EN     = 0;
    localparam int unsigned B_DUAL   = 1;
    localparam int unsigned B_INTPNL = 2;
    localparam int unsigned B_TOPEN  = 31;
    localparam int unsigned S0_DONE  = 0;
    localparam int unsigned S0_ABORT = 1;
    localparam int unsigned S0_FAULT = 2;
    localparam int unsigned S0_W1C_W = 12;
    localparam int unsigned S0_CH_LO = 28;
    localparam int unsigned IMSK_LO  = 12;
    localparam int unsigned PNL_LO   = 8;
    localparam int unsigned PNL_W    = 4;

    typedef enum logic [4:0] {
        SEL_BAD, SEL_CTRL0, SEL_CTRL1, SEL_CTRL2, SEL_CTRL3, SEL_CTRL4,
        SEL_CTRL5, SEL_STAT0, SEL_STAT1, SEL_OV1A, SEL_OV1B, SEL_OV2A,
        SEL_OV2B, SEL_CURS, SEL_CMD, SEL_TCOL, SEL_TEST, SEL_BURST,
        SEL_RSVD, SEL_BR, SEL_DESC
    } reg_sel_e;

endpackage

// File: rtl/dispctl_decode.sv
module dispctl_decode
    import dispctl_pkg::*;
#(
    parameter int unsigned NCH   = 7,
    parameter int unsigned IDX_W = 3
) (
    input  logic [31:0]      addr,
    output reg_sel_e         sel,
    output logic [IDX_W-1:0] idx
);

    localparam logic [31:0] BR_END = OFS_BR + 32'(4 * NCH);

    logic [31:0] dma_off;
    logic [31:0] dma_chn;
    logic [31:0] br_off;

    assign dma_off = addr - OFS_DMA;
    assign dma_chn = dma_off >> 4;
    assign br_off  = addr - OFS_BR;

    always_comb begin
        sel = SEL_BAD;
        idx = '0;
        if (addr >= OFS_DMA && addr <= OFS_DMA_Z) begin
            if (dma_off[3:0] == DESC_SUB && dma_chn < NCH) begin
                sel = SEL_DESC;
                idx = dma_off[IDX_W+3:4];
            end
        end else if (addr >= OFS_BR && addr < BR_END && addr[1:0] == 2'b00) begin
            sel = SEL_BR;
            idx = br_off[IDX_W+1:2];
        end else begin
            case (addr)
                OFS_CTRL0: sel = SEL_CTRL0;
                OFS_CTRL1: sel = SEL_CTRL1;
                OFS_CTRL2: sel = SEL_CTRL2;
                OFS_CTRL3: sel = SEL_CTRL3;
                OFS_CTRL4: sel = SEL_CTRL4;
                OFS_CTRL5: sel = SEL_CTRL5;
                OFS_STAT0: sel = SEL_STAT0;
                OFS_STAT1: sel = SEL_STAT1;
                OFS_OV1A:  sel = SEL_OV1A;
                OFS_OV1B:  sel = SEL_OV1B;
                OFS_OV2A:  sel = SEL_OV2A;
                OFS_OV2B:  sel = SEL_OV2B;
                OFS_CURS:  sel = SEL_CURS;
                OFS_CMD:   sel = SEL_CMD;
                OFS_TCOL:  sel = SEL_TCOL;
                OFS_TEST:  sel = SEL_TEST;
                OFS_BURST: sel = SEL_BURST;
                OFS_RSVD:  sel = SEL_RSVD;
                default:   sel = SEL_BAD;
            endcase
        end
    end

endmodule

// File: rtl/dispctl_status.sv
module dispctl_status
    import dispctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_s0,
    input  logic                wr_s1,
    input  logic [31:0]         wdata,
    input  logic                done_set,
    input  logic                abort_set,
    input  logic                fault_vld,
    input  logic [2:0]          fault_ch,
    input  logic [31:0]         stat1_evt,
    input  logic [S0_W1C_W-1:0] irq_mask,
    output logic [31:0]         stat0,
    output logic [31:0]         stat1,
    output logic                irq
);

    logic [31:0] s0_nxt;
    logic [31:0] s1_nxt;

    always_comb begin
        s0_nxt = stat0;
        if (wr_s0) begin
            s0_nxt[S0_W1C_W-1:0] = stat0[S0_W1C_W-1:0] & ~wdata[S0_W1C_W-1:0];
            if (wdata[S0_FAULT]) begin
                s0_nxt[S0_CH_LO +: 3] = 3'b000;
            end
        end
        if (done_set) begin
            s0_nxt[S0_DONE] = 1'b1;
        end
        if (abort_set) begin
            s0_nxt[S0_ABORT] = 1'b1;
        end
        if (fault_vld) begin
            s0_nxt[S0_FAULT]      = 1'b1;
            s0_nxt[S0_CH_LO +: 3] = fault_ch;
        end
    end

    always_comb begin
        s1_nxt = stat1;
        if (wr_s1) begin
            s1_nxt = stat1 & ~(wdata & MSK_STAT1);
        end
        s1_nxt = s1_nxt | (stat1_evt & MSK_STAT1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat0 <= '0;
            stat1 <= '0;
        end else begin
            stat0 <= s0_nxt;
            stat1 <= s1_nxt;
        end
    end

    assign irq = |(stat0[S0_W1C_W-1:0] & ~irq_mask);

    AST_STAT1_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s1 && stat1_evt == 32'h0) |=> ((stat1 & $past(wdata & MSK_STAT1)) == 32'h0)); // R7

    AST_FAULT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_vld |=> (stat0[S0_FAULT] && stat0[S0_CH_LO +: 3] == $past(fault_ch))); // R6

    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat0[S0_W1C_W-1:0] != '0)); // R12

endmodule

// File: rtl/dispctl_chan.sv
module dispctl_chan
    import dispctl_pkg::*;
#(
    parameter int unsigned NCH   = 7,
    parameter int unsigned IDX_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_desc,
    input  logic                  wr_br,
    input  logic [IDX_W-1:0]      idx,
    input  logic [31:0]           wdata,
    output logic [NCH-1:0][31:0]  desc_o,
    output logic [NCH-1:0][31:0]  br_o
);

    logic [31:0] desc_q [NCH];
    logic [31:0] br_q   [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                desc_q[g] <= '0;
                br_q[g]   <= '0;
            end else begin
                if (wr_desc && idx == IDX_W'(g)) begin
                    desc_q[g] <= wdata & MSK_DESC;
                end
                if (wr_br && idx == IDX_W'(g)) begin
                    br_q[g] <= wdata & MSK_BR;
                end
            end
        end
        assign desc_o[g] = desc_q[g];
        assign br_o[g]   = br_q[g];
    end

    AST_DESC_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_desc |=> (desc_o[$past(idx)] == ($past(wdata) & MSK_DESC))); // R8

endmodule

// File: rtl/dispctl_regs.sv
module dispctl_regs
    import dispctl_pkg::*;
#(
    parameter int unsigned NCH = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [31:0]    addr,
    input  logic [31:0]    wdata,
    input  logic           fault_vld,
    input  logic [2:0]     fault_ch,
    input  logic [31:0]    stat1_evt,
    output logic [31:0]    rdata,
    output logic           err_o,
    output logic           irq_o,
    output logic [NCH-1:0] chan_active_o
);

    localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

    reg_sel_e               sel;
    logic [IDX_W-1:0]       idx;
    logic [31:0]            ctrl_q [NUM_CTRL];
    logic [31:0]            ov1a_q, ov1b_q, ov2a_q, ov2b_q;
    logic [31:0]            curs_q, cmd_q, tcol_q, test_q, burst_q;
    logic [31:0]            stat0, stat1;
    logic [NCH-1:0][31:0]   desc_v;
    logic [NCH-1:0][31:0]   br_v;
    logic [31:0]            rd_mux;
    logic                   wr_c0;
    logic                   done_set;
    logic                   abort_set;
    logic                   err_q;
    logic [31:0]            rdata_q;

    dispctl_decode #(.NCH(NCH), .IDX_W(IDX_W)) u_dec (
        .addr (addr),
        .sel  (sel),
        .idx  (idx)
    );

    // control-word side effects
    assign wr_c0     = wr_en && (sel == SEL_CTRL0);
    assign done_set  = wr_c0 && ctrl_q[0][B_EN] && !wdata[B_EN];
    assign abort_set = wr_c0 && (ctrl_q[3][PNL_LO +: PNL_W] != '0)
                       && wdata[B_EN] && !wdata[B_INTPNL];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CTRL; i++) begin
                ctrl_q[i] <= '0;
            end
            ov1a_q  <= '0;
            ov1b_q  <= '0;
            ov2a_q  <= '0;
            ov2b_q  <= '0;
            curs_q  <= '0;
            cmd_q   <= '0;
            tcol_q  <= '0;
            test_q  <= '0;
            burst_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL0: ctrl_q[0] <= wdata & MSK_CTRL0;
                SEL_CTRL1: ctrl_q[1] <= wdata;
                SEL_CTRL2: ctrl_q[2] <= wdata;
                SEL_CTRL3: ctrl_q[3] <= wdata & MSK_CTRL3;
                SEL_CTRL4: ctrl_q[4] <= wdata & MSK_CTRL4;
                SEL_CTRL5: ctrl_q[5] <= wdata & MSK_CTRL5;
                SEL_OV1A:  ov1a_q    <= wdata & MSK_OVA;
                SEL_OV1B:  ov1b_q    <= wdata & MSK_OV1B;
                SEL_OV2A:  ov2a_q    <= wdata & MSK_OVA;
                SEL_OV2B:  ov2b_q    <= wdata & MSK_OV2B;
                SEL_CURS:  curs_q    <= wdata & MSK_CURS;
                SEL_CMD:   cmd_q     <= wdata & MSK_CMD;
                SEL_TCOL:  tcol_q    <= wdata & MSK_TCOL;
                SEL_TEST:  test_q    <= wdata & MSK_TEST;
                SEL_BURST: burst_q   <= wdata & MSK_BURST;
                default:   ;
            endcase
        end
    end

    dispctl_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_s0     (wr_en && sel == SEL_STAT0),
        .wr_s1     (wr_en && sel == SEL_STAT1),
        .wdata     (wdata),
        .done_set  (done_set),
        .abort_set (abort_set),
        .fault_vld (fault_vld),
        .fault_ch  (fault_ch),
        .stat1_evt (stat1_evt),
        .irq_mask  (ctrl_q[0][IMSK_LO +: S0_W1C_W]),
        .stat0     (stat0),
        .stat1     (stat1),
        .irq       (irq_o)
    );

    dispctl_chan #(.NCH(NCH), .IDX_W(IDX_W)) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_desc (wr_en && sel == SEL_DESC),
        .wr_br   (wr_en && sel == SEL_BR),
        .idx     (idx),
        .wdata   (wdata),
        .desc_o  (desc_v),
        .br_o    (br_v)
    );

    // channel-active mapping
    for (genvar g = 0; g < NCH; g++) begin : g_act
        if (g == 0) begin : g_base
            assign chan_active_o[g] = ctrl_q[0][B_EN];
        end else if (g == 1) begin : g_ov1
            assign chan_active_o[g] = ov1a_q[B_TOPEN] | ctrl_q[0][B_DUAL];
        end else if (g <= 4) begin : g_ov2
            assign chan_active_o[g] = ov2a_q[B_TOPEN];
        end else if (g == 5) begin : g_cur
            assign chan_active_o[g] = curs_q[B_TOPEN];
        end else begin : g_idle
            assign chan_active_o[g] = 1'b0;
        end
    end

    // read path
    always_comb begin
        case (sel)
            SEL_CTRL0: rd_mux = ctrl_q[0];
            SEL_CTRL1: rd_mux = ctrl_q[1];
            SEL_CTRL2: rd_mux = ctrl_q[2];
            SEL_CTRL3: rd_mux = ctrl_q[3];
            SEL_CTRL4: rd_mux = ctrl_q[4];
            SEL_CTRL5: rd_mux = ctrl_q[5];
            SEL_STAT0: rd_mux = stat0;
            SEL_STAT1: rd_mux = stat1;
            SEL_OV1A:  rd_mux = ov1a_q;
            SEL_OV1B:  rd_mux = ov1b_q;
            SEL_OV2A:  rd_mux = ov2a_q;
            SEL_OV2B:  rd_mux = ov2b_q;
            SEL_CURS:  rd_mux = curs_q;
            SEL_CMD:   rd_mux = cmd_q;
            SEL_TCOL:  rd_mux = tcol_q;
            SEL_TEST:  rd_mux = test_q;
            SEL_BURST: rd_mux = burst_q;
            SEL_BR:    rd_mux = br_v[idx];
            SEL_DESC:  rd_mux = desc_v[idx];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (rd_en) begin
                rdata_q <= rd_mux;
            end
            err_q <= (wr_en || rd_en) && (sel == SEL_BAD);
        end
    end

    assign rdata = rdata_q;
    assign err_o = err_q;

    AST_DONE_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c0 && ctrl_q[0][B_EN] && !wdata[B_EN]) |=> stat0[S0_DONE]); // R4

    AST_ABORT_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c0 && ctrl_q[3][PNL_LO +: PNL_W] != '0 && wdata[B_EN] && !wdata[B_INTPNL])
        |=> stat0[S0_ABORT]); // R5

    AST_CH0_TRACKS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c0 |=> (chan_active_o[0] == $past(wdata[B_EN]))); // R9

    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(wr_en || rd_en)); // R11

    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && sel == SEL_RSVD) |=> !err_o); // R10

    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R13

endmodule

// File: tb/tb_dispctl_regs.sv
module tb_dispctl_regs;

    localparam int NCH = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] addr = '0, wdata = '0;
    logic        fault_vld = 1'b0;
    logic [2:0]  fault_ch = '0;
    logic [31:0] stat1_evt = '0;
    logic [31:0] rdata;
    logic        err_o, irq_o;
    logic [NCH-1:0] chan_active_o;

    always #4 clk = ~clk;

    dispctl_regs #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .fault_vld(fault_vld), .fault_ch(fault_ch),
        .stat1_evt(stat1_evt), .rdata(rdata), .err_o(err_o), .irq_o(irq_o),
        .chan_active_o(chan_active_o)
    );

    int nchk = 0, nerr = 0;
    bit run = 0;
    bit exp_err = 0;

    // behavioural model state
    logic [31:0] mc [6];
    logic [31:0] mo1a, mo1b, mo2a, mo2b, mcur, mcmd, mtcol, mtest, mburst;
    logic [31:0] ms0, ms1;
    logic [31:0] mdesc [NCH];
    logic [31:0] mbr [NCH];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 6; i++) mc[i] = 0;
        for (int i = 0; i < NCH; i++) begin mdesc[i] = 0; mbr[i] = 0; end
        mo1a = 0; mo1b = 0; mo2a = 0; mo2b = 0; mcur = 0; mcmd = 0;
        mtcol = 0; mtest = 0; mburst = 0; ms0 = 0; ms1 = 0;
    endtask

    function automatic string req_of(input logic [31:0] a);
        if (a <= 32'h14) return "R2";
        if (a == 32'h20) return "R6";
        if (a == 32'h24) return "R7";
        if (a == 32'h54) return "R10";
        if (a >= 32'h200) return "R8";
        return "R3";
    endfunction

    // 0 unmapped, 1 mapped, 2 reserved
    function automatic int mread(input logic [31:0] a, output logic [31:0] v);
        v = 0;
        if (a >= 32'h200 && a <= 32'h1000) begin
            int off;
            off = int'(a - 32'h200);
            if (off % 16 == 0 && off / 16 < NCH) begin v = mdesc[off/16]; return 1; end
            return 0;
        end
        if (a >= 32'h60 && a < 32'h60 + 4 * NCH && a % 4 == 0) begin
            v = mbr[(a - 32'h60) / 4];
            return 1;
        end
        case (a)
            32'h00: v = mc[0];  32'h04: v = mc[1];  32'h08: v = mc[2];
            32'h0C: v = mc[3];  32'h10: v = mc[4];  32'h14: v = mc[5];
            32'h20: v = ms0;    32'h24: v = ms1;
            32'h30: v = mo1a;   32'h34: v = mo1b;   32'h38: v = mo2a;  32'h3C: v = mo2b;
            32'h40: v = mcur;   32'h44: v = mcmd;   32'h48: v = mtcol; 32'h4C: v = mtest;
            32'h50: v = mburst;
            32'h54: return 2;
            default: return 0;
        endcase
        return 1;
    endfunction

    function automatic logic [NCH-1:0] exp_chan();
        logic [NCH-1:0] c;
        c = '0;
        c[0] = mc[0][0];
        c[1] = mo1a[31] | mc[0][1];
        c[2] = mo2a[31]; c[3] = mo2a[31]; c[4] = mo2a[31];
        c[5] = mcur[31];
        return c;
    endfunction

    function automatic logic exp_irq();
        return |(ms0[11:0] & ~mc[0][23:12]);
    endfunction

    // one bus cycle, model updated after the edge
    task automatic cyc(input bit w, input bit r, input logic [31:0] a, input logic [31:0] d,
                       input bit f = 0, input logic [2:0] fc = 0, input logic [31:0] e1 = 0);
        logic [31:0] rv, n0;
        int kind;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        fault_vld = f; fault_ch = fc; stat1_evt = e1;
        @(posedge clk);
        #1;
        kind = mread(a, rv);
        n0 = ms0;
        if (w && kind == 1) begin
            if (a == 32'h00) begin
                if (mc[0][0] && !d[0]) n0[0] = 1;
                if (mc[3][11:8] != 0 && d[0] && !d[2]) n0[1] = 1;
                mc[0] = d & 32'h07FF_FFFF;
            end
            else if (a == 32'h04) mc[1] = d;
            else if (a == 32'h08) mc[2] = d;
            else if (a == 32'h0C) mc[3] = d & 32'hEFFF_FFFF;
            else if (a == 32'h10) mc[4] = d & 32'h83FF_81FF;
            else if (a == 32'h14) mc[5] = d & 32'h3F3F_3F3F;
            else if (a == 32'h20) begin
                n0[11:0] = n0[11:0] & ~d[11:0];
                if (d[2]) n0[30:28] = 0;
            end
            else if (a == 32'h24) ms1 = ms1 & ~(d & 32'h003E_3F3F);
            else if (a == 32'h30) mo1a = d & 32'h80FF_FFFF;
            else if (a == 32'h34) mo1b = d & 32'h000F_FFFF;
            else if (a == 32'h38) mo2a = d & 32'h80FF_FFFF;
            else if (a == 32'h3C) mo2b = d & 32'h007F_FFFF;
            else if (a == 32'h40) mcur = d & 32'h81FF_FFE7;
            else if (a == 32'h44) mcmd = d & 32'hFF;
            else if (a == 32'h48) mtcol = d & 32'h00FF_FFFF;
            else if (a == 32'h4C) mtest = d & 32'h7FFF;
            else if (a == 32'h50) mburst = d & 32'hF;
            else if (a >= 32'h200) mdesc[(a - 32'h200) / 16] = d & 32'hFFFF_FFF0;
            else mbr[(a - 32'h60) / 4] = d & 32'hFFFF_FFF3;
        end
        if (f) begin n0[2] = 1; n0[30:28] = fc; end
        ms0 = n0;
        ms1 = ms1 | (e1 & 32'h003E_3F3F);
        exp_err = (w || r) && kind == 0;
        if (r) chk(rdata === rv, (kind == 0) ? "R11" : (kind == 2) ? "R10" : req_of(a), rdata, rv);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        cyc(1, 0, a, d);
    endtask

    task automatic rd(input logic [31:0] a);
        cyc(0, 1, a, 0);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0);
    endtask

    // compare every clock
    always @(negedge clk) begin
        if (run) begin
            chk(chan_active_o === exp_chan(), "R9", 32'(chan_active_o), 32'(exp_chan()));
            chk(irq_o === exp_irq(), "R12", 32'(irq_o), 32'(exp_irq()));
            chk(err_o === exp_err, "R11", 32'(err_o), 32'(exp_err));
        end
    end

    logic [31:0] alist [32];

    initial begin
        alist = '{32'h000, 32'h004, 32'h008, 32'h00C, 32'h010, 32'h014, 32'h020, 32'h024,
                  32'h030, 32'h034, 32'h038, 32'h03C, 32'h040, 32'h044, 32'h048, 32'h04C,
                  32'h050, 32'h054, 32'h060, 32'h068, 32'h078, 32'h07C, 32'h200, 32'h230,
                  32'h260, 32'h264, 32'h270, 32'h1000, 32'h0FC, 32'h018, 32'h002, 32'h000};
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        run = 1;
        // R1: reset state on every output and register
        chk(rdata === 0 && err_o === 0 && irq_o === 0 && chan_active_o === 0, "R1",
            {rdata[27:0], err_o, irq_o, 2'b0}, 0);
        foreach (alist[i]) rd(alist[i]);

        // R2/R3: masks
        for (int i = 0; i < 6; i++) begin wr(32'(4 * i), 32'hFFFF_FFFE); rd(32'(4 * i)); end
        for (int a = 32'h30; a <= 32'h50; a += 4) begin wr(32'(a), 32'hFFFF_FFFF); rd(32'(a)); end
        for (int i = 0; i < NCH; i++) begin
            wr(32'h60 + 32'(4 * i), 32'hA5A5_5A5F ^ 32'(i)); rd(32'h60 + 32'(4 * i));
            wr(32'h200 + 32'(16 * i), 32'h1234_567F + 32'(i)); rd(32'h200 + 32'(16 * i));  // R8
        end

        // R8/R11: bad descriptor subregisters and channels
        wr(32'h204, 32'hFFFF_FFFF); idle();
        wr(32'h270, 32'hFFFF_FFFF); idle();
        wr(32'h1000, 32'h1); rd(32'h1000); rd(32'h0FC); rd(32'h200);
        // R10: reserved offset
        wr(32'h054, 32'hFFFF_FFFF); rd(32'h054);

        // clean control state
        for (int a = 0; a <= 32'h50; a += 4) wr(32'(a), 0);
        wr(32'h20, 32'hFFFF_FFFF); wr(32'h24, 32'hFFFF_FFFF);

        // R4: disable edge
        wr(32'h00, 32'h1); wr(32'h00, 32'h0); rd(32'h20);
        wr(32'h00, 32'h0); wr(32'h20, 32'h1); rd(32'h20);
        // R5: abort condition with and without internal panel
        wr(32'h0C, 32'h0000_0300); wr(32'h00, 32'h5); rd(32'h20);
        wr(32'h00, 32'h0); wr(32'h20, 32'h3); wr(32'h00, 32'h1); rd(32'h20);
        wr(32'h0C, 32'h0); wr(32'h00, 32'h0); wr(32'h20, 32'hFFF);
        // R12: mask field
        wr(32'h00, 32'h1); wr(32'h00, 32'h0000_1000); idle();
        wr(32'h00, 32'h0); idle(); wr(32'h20, 32'h1); idle();

        // R6: fault field and linked clear
        cyc(0, 0, 0, 0, 1, 3'd5); rd(32'h20);
        wr(32'h20, 32'h1); rd(32'h20);
        wr(32'h20, 32'h4); rd(32'h20);
        cyc(0, 0, 0, 0, 1, 3'd6);
        cyc(1, 0, 32'h20, 32'h4, 1, 3'd2); rd(32'h20);
        // R7: status 1
        cyc(0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF); rd(32'h24);
        wr(32'h24, 32'h0000_0F0F); rd(32'h24);
        cyc(1, 0, 32'h24, 32'hFFFF_FFFF, 0, 0, 32'h0000_0001); rd(32'h24);
        // R13: repeated reads leave state alone
        rd(32'h24); rd(32'h24); idle(); idle();

        // R9: channel sources
        wr(32'h00, 32'h2); wr(32'h00, 32'h0); wr(32'h30, 32'h8000_0000);
        wr(32'h38, 32'h8000_0000); wr(32'h40, 32'h8000_0000);
        wr(32'h30, 0); wr(32'h38, 0); wr(32'h40, 0);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a, d;
            int op;
            a = alist[$urandom_range(0, 31)];
            d = $urandom();
            op = $urandom_range(0, 9);
            if (op < 5) cyc(1, 0, a, d, ($urandom_range(0, 7) == 0), 3'($urandom()),
                            ($urandom_range(0, 5) == 0) ? $urandom() : 32'h0);
            else if (op < 9) cyc(0, 1, a, 0, ($urandom_range(0, 7) == 0), 3'($urandom()));
            else idle();
        end

        idle(); idle();
        run = 0;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #(8 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule